// File: doc/BRIEF.md
# Trigger-Paced Sample Release Controller

This block sits on the radio side of a fronthaul link, between a set of first-stage sample FIFOs, which the fronthaul deframer fills, and a set of second-stage FIFOs, which cross into the converter clock domain. There is one FIFO pair per lane, and a lane is the I or the Q component of one antenna-carrier. Samples wait in the first stage until a periodic trigger arrives. After each trigger the controller moves a fixed quota of samples per lane into the second stage. It moves them one beat at a time, with all lanes in lockstep, and it moves nothing beyond the quota.

The second stage is held at a low occupancy mark, so that samples which are not yet due stay in the first stage. A trigger can arrive before the previous quota has fully moved. In that case the leftover beats are popped from the first stage and thrown away, and only then does the new quota start. This realigns transmission on every trigger. On the very first trigger, a configurable number of extra beats is added once, as a cushion against underflow. Second-stage underflow is not repaired. It is only flagged and counted. Discarded beats are also counted. The controller runs entirely in the internal clock domain.

Top module: `sample_release_ctrl`

## Requirements
- R1: Before the first trigger, no first-stage pop and no second-stage push occurs.
- R2: The first trigger grants QUOTA+BACKUP beats. A later trigger that finds the previous quota fully moved grants QUOTA beats. No push occurs once the granted beats are used up.
- R3: A transfer beat pops every lane and pushes every lane in the same cycle, and only when every lane's first stage is non-empty and every lane's second-stage level is below HOLD_LEVEL. Pops and pushes are all-ones or all-zeros across lanes.
- R4: In a cycle where the trigger input is high, no pop and no push occurs.
- R5: A trigger that finds N beats of the current quota still unmoved causes exactly N discard beats. Each discard beat pops every lane without pushing, requires only that every first stage is non-empty, and is followed by a fresh QUOTA grant.
- R6: A trigger that arrives while discards are still pending adds QUOTA to the pending discard count, saturating at the maximum of REM_W bits.
- R7: On a push, each lane's second-stage data equals that lane's first-stage data.
- R8: drop_count_o counts discard beats, saturates at 65535, and never decreases outside reset.
- R9: After the first push, underflow_o is high in any cycle where some lane's second-stage level is zero. underflow_count_o counts those cycles and saturates.
- R10: After reset, both counters are zero and underflow_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Periodic release trigger, one-cycle pulse |
| s1_nonempty_i | input | LANES | First-stage FIFO not empty, per lane |
| s1_data_i | input | LANES*DW | First-stage head sample, per lane |
| s1_pop_o | output | LANES | First-stage read strobe, per lane |
| s2_level_i | input | LANES*LVL_W | Second-stage occupancy, per lane |
| s2_push_o | output | LANES | Second-stage write strobe, per lane |
| s2_data_o | output | LANES*DW | Second-stage write data, per lane |
| underflow_o | output | 1 | Some second stage is empty after startup |
| drop_count_o | output | CNT_W | Saturating count of discarded beats |
| underflow_count_o | output | CNT_W | Saturating count of underflow cycles |

## Verification
The bench builds the block with two lanes, 8-bit samples, QUOTA=3, BACKUP=1, HOLD_LEVEL=2 and a 3-bit level. With a quota this small, complete grants, partial grants, discard sequences and retriggers during a discard all fit into a short cycle table. Because REM_W and CNT_W keep their 16-bit width, a burst of back-to-back triggers pushes the pending discard count to its ceiling. The drop counter can then be driven to saturation and held there in an affordable number of cycles.

// File: rtl/srel_pkg.sv
package srel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DROP = 2'd2
    } srel_state_e;
endpackage

// File: rtl/srel_lane_gate.sv
module srel_lane_gate #(
    parameter int DW         = 16,
    parameter int LVL_W      = 4,
    parameter int HOLD_LEVEL = 2
) (
    input  logic             nonempty_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [DW-1:0]    data_i,
    input  logic             pop_i,
    input  logic             push_i,
    output logic             ready_o,
    output logic             starved_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic [DW-1:0]    data_o
);
    localparam logic [LVL_W-1:0] HOLD_V = LVL_W'(HOLD_LEVEL);

    always_comb begin
        ready_o   = nonempty_i && (level_i < HOLD_V);
        starved_o = (level_i == '0);
        rd_o      = pop_i;
        wr_o      = push_i;
        data_o    = data_i;
    end
endmodule

// File: rtl/srel_sat_counter.sv
module srel_sat_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [WIDTH-1:0] count_o
);
    logic [WIDTH-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc_i && (count_q != '1)) count_d = count_q + WIDTH'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;
endmodule

// File: rtl/srel_pacer.sv
module srel_pacer
    import srel_pkg::*;
#(
    parameter int QUOTA  = 8,
    parameter int BACKUP = 2,
    parameter int REM_W  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic gate_ok_i,
    input  logic avail_i,
    output logic pop_o,
    output logic push_o,
    output logic drop_o
);
    localparam logic [REM_W-1:0] QUOTA_V = REM_W'(QUOTA);
    localparam logic [REM_W-1:0] FIRST_V = REM_W'(QUOTA + BACKUP);

    typedef struct packed {
        srel_state_e      st;
        logic [REM_W-1:0] move_rem;
        logic [REM_W-1:0] drop_rem;
    } pacer_t;

    pacer_t p_d, p_q;
    logic   move_beat, drop_beat;
    logic [REM_W:0] drop_sum;

    always_comb begin
        move_beat = !trig_i && (p_q.st == ST_MOVE) && (p_q.move_rem != '0) && gate_ok_i;
        drop_beat = !trig_i && (p_q.st == ST_DROP) && (p_q.drop_rem != '0) && avail_i;
        drop_sum  = {1'b0, p_q.drop_rem} + {1'b0, QUOTA_V};
        p_d       = p_q;
        unique case (p_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    p_d.st       = ST_MOVE;
                    p_d.move_rem = FIRST_V;
                end
            end
            ST_MOVE: begin
                if (trig_i) begin
                    if (p_q.move_rem == '0) begin
                        p_d.move_rem = QUOTA_V;
                    end else begin
                        p_d.st       = ST_DROP;
                        p_d.drop_rem = p_q.move_rem;
                        p_d.move_rem = '0;
                    end
                end else if (move_beat) begin
                    p_d.move_rem = p_q.move_rem - REM_W'(1);
                end
            end
            ST_DROP: begin
                if (trig_i) begin
                    p_d.drop_rem = drop_sum[REM_W] ? '1 : drop_sum[REM_W-1:0];
                end else if (drop_beat) begin
                    if (p_q.drop_rem == REM_W'(1)) begin
                        p_d.st       = ST_MOVE;
                        p_d.drop_rem = '0;
                        p_d.move_rem = QUOTA_V;
                    end else begin
                        p_d.drop_rem = p_q.drop_rem - REM_W'(1);
                    end
                end
            end
            default: p_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.st       <= ST_IDLE;
            p_q.move_rem <= '0;
            p_q.drop_rem <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pop_o  = move_beat || drop_beat;
    assign push_o = move_beat;
    assign drop_o = drop_beat;
endmodule

// File: rtl/sample_release_ctrl.sv
module sample_release_ctrl #(
    parameter int LANES      = 4,
    parameter int DW         = 16,
    parameter int LVL_W      = 4,
    parameter int HOLD_LEVEL = 2,
    parameter int QUOTA      = 8,
    parameter int BACKUP     = 2,
    parameter int REM_W      = 16,
    parameter int CNT_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_i,
    input  logic [LANES-1:0]       s1_nonempty_i,
    input  logic [LANES*DW-1:0]    s1_data_i,
    output logic [LANES-1:0]       s1_pop_o,
    input  logic [LANES*LVL_W-1:0] s2_level_i,
    output logic [LANES-1:0]       s2_push_o,
    output logic [LANES*DW-1:0]    s2_data_o,
    output logic                   underflow_o,
    output logic [CNT_W-1:0]       drop_count_o,
    output logic [CNT_W-1:0]       underflow_count_o
);
    logic [LANES-1:0] lane_ready, lane_starved;
    logic gate_ok, avail, pop, push, drop;

    typedef struct packed {
        logic armed;
    } top_t;
    top_t t_d, t_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        srel_lane_gate #(
            .DW(DW), .LVL_W(LVL_W), .HOLD_LEVEL(HOLD_LEVEL)
        ) u_gate (
            .nonempty_i (s1_nonempty_i[g]),
            .level_i    (s2_level_i[g*LVL_W +: LVL_W]),
            .data_i     (s1_data_i[g*DW +: DW]),
            .pop_i      (pop),
            .push_i     (push),
            .ready_o    (lane_ready[g]),
            .starved_o  (lane_starved[g]),
            .rd_o       (s1_pop_o[g]),
            .wr_o       (s2_push_o[g]),
            .data_o     (s2_data_o[g*DW +: DW])
        );
    end

    assign gate_ok = &lane_ready;
    assign avail   = &s1_nonempty_i;

    srel_pacer #(
        .QUOTA(QUOTA), .BACKUP(BACKUP), .REM_W(REM_W)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .gate_ok_i (gate_ok),
        .avail_i   (avail),
        .pop_o     (pop),
        .push_o    (push),
        .drop_o    (drop)
    );

    always_comb begin
        t_d = t_q;
        if (push) t_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q.armed <= 1'b0;
        else        t_q <= t_d;
    end

    assign underflow_o = t_q.armed && (|lane_starved);

    srel_sat_counter #(.WIDTH(CNT_W)) u_drop_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(drop), .count_o(drop_count_o)
    );

    srel_sat_counter #(.WIDTH(CNT_W)) u_uf_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(underflow_o), .count_o(underflow_count_o)
    );
endmodule

// File: rtl/srel_checker.sv
module srel_checker #(
    parameter int LANES      = 4,
    parameter int DW         = 16,
    parameter int LVL_W      = 4,
    parameter int HOLD_LEVEL = 2,
    parameter int CNT_W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trig_i,
    input logic [LANES-1:0]       s1_nonempty_i,
    input logic [LANES*DW-1:0]    s1_data_i,
    input logic [LANES-1:0]       s1_pop_o,
    input logic [LANES*LVL_W-1:0] s2_level_i,
    input logic [LANES-1:0]       s2_push_o,
    input logic [LANES*DW-1:0]    s2_data_o,
    input logic [CNT_W-1:0]       drop_count_o
);
    logic all_low;
    always_comb begin
        all_low = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (s2_level_i[i*LVL_W +: LVL_W] >= LVL_W'(HOLD_LEVEL)) all_low = 1'b0;
    end

    assert_push_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_push_o != '0) |-> ((&s1_nonempty_i) && all_low));

    assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s1_pop_o == '0) || (s1_pop_o == '1)) && ((s2_push_o == '0) || (s2_push_o == '1)));

    assert_push_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_push_o != '0) |-> (s1_pop_o == '1));

    assert_trig_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |-> (s1_pop_o == '0));

    assert_data_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s2_push_o[0] |-> (s2_data_o[DW-1:0] == s1_data_i[DW-1:0]));

    assert_drop_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_pop_o[0] && !s2_push_o[0] && (drop_count_o != '1))
        |=> (drop_count_o == $past(drop_count_o) + CNT_W'(1)));

    assert_drop_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (drop_count_o >= $past(drop_count_o)));
endmodule

bind sample_release_ctrl srel_checker #(
    .LANES(LANES), .DW(DW), .LVL_W(LVL_W), .HOLD_LEVEL(HOLD_LEVEL), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .s1_nonempty_i(s1_nonempty_i),
    .s1_data_i(s1_data_i), .s1_pop_o(s1_pop_o), .s2_level_i(s2_level_i),
    .s2_push_o(s2_push_o), .s2_data_o(s2_data_o), .drop_count_o(drop_count_o)
);

// File: tb/sim_sample_release_ctrl.sv
`timescale 1ns/1ps
module sim_sample_release_ctrl;
    localparam int LANES = 2, DW = 8, LVL_W = 3, HOLD = 2, QUOTA = 3, BACKUP = 1;
    localparam int NV = 27;

    // fields: trig[8] nonempty[7:6] level[5:3] exp_pop[2] exp_push[1] exp_uf[0]
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0},  // 0  idle R1
        {1'b1, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0},  // 1  first trigger R4
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b0},  // 2
        {1'b0, 2'b11, 3'd1, 1'b1, 1'b1, 1'b0},  // 3
        {1'b0, 2'b11, 3'd2, 1'b0, 1'b0, 1'b0},  // 4  level at hold R3
        {1'b0, 2'b01, 3'd0, 1'b0, 1'b0, 1'b1},  // 5  lane1 empty R3
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 6
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 7  4th beat
        {1'b0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1},  // 8  quota done R2
        {1'b1, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1},  // 9
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 10
        {1'b1, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1},  // 11 early trigger R5
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 12 drop
        {1'b0, 2'b10, 3'd0, 1'b0, 1'b0, 1'b1},  // 13 lane0 empty
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 14 drop
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 15
        {1'b1, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1},  // 16 drop 2
        {1'b1, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1},  // 17 retrigger R6 -> 5
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 18
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 19
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 20
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 21
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // 22
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 23
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 24
        {1'b0, 2'b11, 3'd0, 1'b1, 1'b1, 1'b1},  // 25
        {1'b0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b1}   // 26
    };

    logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
    logic [LANES-1:0]       ne = '0;
    logic [LANES*DW-1:0]    s1_data = '0;
    logic [LANES-1:0]       pop, push;
    logic [LANES*LVL_W-1:0] lvl = '0;
    logic [LANES*DW-1:0]    s2_data;
    logic                   uf;
    logic [15:0]            drop_cnt, uf_cnt;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sample_release_ctrl #(
        .LANES(LANES), .DW(DW), .LVL_W(LVL_W), .HOLD_LEVEL(HOLD),
        .QUOTA(QUOTA), .BACKUP(BACKUP), .REM_W(16), .CNT_W(16)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .s1_nonempty_i(ne),
        .s1_data_i(s1_data), .s1_pop_o(pop), .s2_level_i(lvl),
        .s2_push_o(push), .s2_data_o(s2_data), .underflow_o(uf),
        .drop_count_o(drop_cnt), .underflow_count_o(uf_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic [1:0] n, input logic [2:0] l0, input logic [2:0] l1);
        @(negedge clk);
        trig = t; ne = n; lvl = {l1, l0};
        #1;
    endtask

    initial begin
        int pushes;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 drop count", 32'(drop_cnt), 0);
        chk("R10 underflow count", 32'(uf_cnt), 0);
        chk("R10 underflow flag", 32'(uf), 0);
        chk("R1 no pop in reset", 32'(pop), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            trig = VEC[i][8]; ne = VEC[i][7:6];
            lvl = {VEC[i][5:3], VEC[i][5:3]};
            s1_data = {8'(i * 7 + 1), 8'(i * 3 + 5)};
            #1;
            chk($sformatf("R2/R3/R4/R5 pop vec %0d", i), 32'(pop), {30'b0, {2{VEC[i][2]}}});
            chk($sformatf("R2/R3/R5 push vec %0d", i), 32'(push), {30'b0, {2{VEC[i][1]}}});
            chk($sformatf("R9 underflow vec %0d", i), 32'(uf), {31'b0, VEC[i][0]});
            if (VEC[i][1]) chk($sformatf("R7 data vec %0d", i), 32'(s2_data), 32'(s1_data));
        end
        drive(1'b0, 2'b00, 3'd1, 3'd1);
        chk("R8 drop count after table (R6 included)", 32'(drop_cnt), 7);
        chk("R9 underflow count", 32'(uf_cnt), 22);
        chk("R9 flag low with levels nonzero", 32'(uf), 0);
        drive(1'b0, 2'b00, 3'd1, 3'd0);
        chk("R9 flag on single starved lane", 32'(uf), 1);

        // saturation run: reset, then stack triggers with empty first stage
        @(negedge clk); rst_n = 1'b0; trig = 0; ne = 0; lvl = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'b00, 3'd0, 3'd0);
        for (int k = 0; k < 21846; k++) drive(1'b1, 2'b00, 3'd0, 3'd0);
        drive(1'b0, 2'b00, 3'd0, 3'd0);
        chk("R5 no pop while first stage empty", 32'(pop), 0);
        pushes = 0;
        for (int k = 0; k < 65540; k++) begin
            drive(1'b0, 2'b11, 3'd0, 3'd0);
            if (push[0]) pushes++;
        end
        chk("R6 pending discards saturate then R8 count", 32'(drop_cnt), 65535);
        chk("R2 quota after long discard", 32'(pushes), 3);
        drive(1'b1, 2'b11, 3'd0, 3'd0);
        drive(1'b0, 2'b00, 3'd0, 3'd0);
        drive(1'b1, 2'b00, 3'd0, 3'd0);
        for (int k = 0; k < 4; k++) drive(1'b0, 2'b11, 3'd0, 3'd0);
        chk("R8 drop counter holds at saturation", 32'(drop_cnt), 65535);
        chk("R2 new quota resumes after discards", 32'(push), 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule